// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block watches the command pins of a four-bank DDR SDRAM. On each rising clock edge it samples clock enable, chip select, the three strobe lines, the bank address and the address bus. It decodes the command and reports it one clock later, together with the bank it targets. Alongside the decode it tracks whether each bank is idle or holds an open row, and it remembers that row.

For each command the monitor also tests the rules the memory imposes: bank state preconditions, minimum command spacing in whole clocks, the quiet time after a mode register load, and the lockout that follows a write carrying auto-precharge. The first rule that is broken sets a violation flag and a two-bit reason code, and both hold until reset. Spacings are given in nanoseconds together with the clock period. The monitor turns them into cycle counts by rounding up, so one build can follow any speed grade. The block is a passive observer for memory controller verification or for a field debug tap. It never drives the bus.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: After reset, cmd_o is 0 (deselect), viol_o and err_code_o are 0, and every bit of bank_active_o is 0.
- R2: With cke high and cs_n low, {ras_n,cas_n,we_n} decodes as 000 mode load (2), 001 refresh (3), 011 activate (4), 101 read (5), 100 write (6), 110 burst stop (7), 010 precharge (8) and 111 no-op (1). The code appears on cmd_o after the clock edge that sampled the pins.
- R3: A cycle with cs_n high or cke low is reported as deselect (0). The other inputs are ignored in that cycle, and no bank state changes.
- R4: bank_o shows the sampled bank address, where values 0 to 3 name banks 0 to 3. An activate stores the full address bus as the row of that bank, and open_row_o shows the stored row of the bank on bank_o.
- R5: A precharge with address bit 10 high closes every bank whatever the bank address is. With bit 10 low it closes only the addressed bank. flag_o shows bit 10 for read, write and precharge, and is 0 otherwise.
- R6: The code 1 (state) is raised by: a read or write to an idle bank, an activate to an open bank, or a mode load or refresh while any bank is open.
- R7: The code 2 (timing) is raised by: a read or write sooner than the activate-to-access count after its activate; an activate sooner than the precharge count after its bank closed; a precharge sooner than the activate-to-precharge count after the activate; an activate sooner than the activate-to-activate count after any activate. At the default 10 ns period these counts are 2, 2, 5 and 2 clocks.
- R8: Any command other than no-op or deselect sent within MRD_CYC-1 clocks after a mode load raises code 3. By default this is the very next clock.
- R9: A read or write with bit 10 high closes its bank at once. A new activate of that bank needs BURST_LEN/2 plus the precharge count clocks (4 by default), or code 2 is raised.
- R10: After a write with bit 10 high, any read or write sooner than BURST_LEN/2+1 clocks (3 by default) raises code 2.
- R11: viol_o and err_code_o hold the first violation until reset. Within one command, code 3 takes priority over code 1, and code 1 over code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Sampled bank address |
| flag_o | output | 1 | Address bit 10 for read, write and precharge |
| open_row_o | output | 13 | Stored row of bank_o |
| bank_active_o | output | 4 | One bit per bank, 1 when a row is open |
| viol_o | output | 1 | Sticky violation flag |
| err_code_o | output | 2 | Reason for the first violation |

## Verification
The assertions assume that the bus pins are stable and known at every rising edge while reset is released. They also assume that reset is released between edges. The bench changes pins only on the falling edge and lets reset go on a falling edge, so both assumptions hold. The checks on the mode-load quiet window and on back-to-back activates take for granted that the default counts are above one clock, and they are built only when that is true. The stimulus issues legal sequences through a long run, and each directed test deliberately breaks exactly one rule right after a fresh reset.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
   typedef enum logic [3:0] {
      CMD_DESEL = 4'd0, CMD_NOP = 4'd1, CMD_MRS = 4'd2, CMD_REF = 4'd3,
      CMD_ACT   = 4'd4, CMD_RD  = 4'd5, CMD_WR  = 4'd6, CMD_BST = 4'd7,
      CMD_PRE   = 4'd8
   } cmd_e;

   typedef enum logic [1:0] {
      ERR_NONE = 2'd0, ERR_STATE = 2'd1, ERR_TIMING = 2'd2, ERR_MRD = 2'd3
   } err_e;

   function automatic int ns2cyc(input int ns, input int tck);
      return (ns + tck - 1) / tck;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_mon_pkg::*;
(
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      if (!cke || cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b000:  cmd = CMD_MRS;
            3'b001:  cmd = CMD_REF;
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b110:  cmd = CMD_BST;
            3'b010:  cmd = CMD_PRE;
            default: cmd = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
   parameter int ROW_W = 13,
   parameter int CW    = 3,
   parameter logic [CW-1:0] RCD_LD = '0,
   parameter logic [CW-1:0] RP_LD  = '0,
   parameter logic [CW-1:0] RAS_LD = '0,
   parameter logic [CW-1:0] AP_LD  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_i,
   input  logic             close_i,
   input  logic             ap_close_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             active_o,
   output logic [ROW_W-1:0] row_o,
   output logic             rcd_busy_o,
   output logic             rp_busy_o,
   output logic             ras_busy_o
);
   logic [CW-1:0] rcd_cnt, rp_cnt, ras_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         row_o    <= '0;
         rcd_cnt  <= '0;
         rp_cnt   <= '0;
         ras_cnt  <= '0;
      end else begin
         if (open_i) begin
            active_o <= 1'b1;
            row_o    <= row_i;
            rcd_cnt  <= RCD_LD;
            ras_cnt  <= RAS_LD;
         end else begin
            if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
            if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
         end
         if (close_i && active_o) begin
            active_o <= 1'b0;
            rp_cnt   <= RP_LD;
         end else if (ap_close_i && active_o) begin
            active_o <= 1'b0;
            rp_cnt   <= AP_LD;
         end else if (rp_cnt != '0) begin
            rp_cnt <= rp_cnt - 1'b1;
         end
      end
   end

   assign rcd_busy_o = (rcd_cnt != '0);
   assign rp_busy_o  = (rp_cnt != '0);
   assign ras_busy_o = (ras_cnt != '0);
endmodule

// File: rtl/ddr_rule_check.sv
module ddr_rule_check
   import ddr_mon_pkg::*;
#(
   parameter int NB   = 4,
   parameter int BA_W = 2
) (
   input  cmd_e            cmd,
   input  logic [BA_W-1:0] bank,
   input  logic            flag,
   input  logic [NB-1:0]   active,
   input  logic [NB-1:0]   rcd_busy,
   input  logic [NB-1:0]   rp_busy,
   input  logic [NB-1:0]   ras_busy,
   input  logic            mrd_busy,
   input  logic            rrd_busy,
   input  logic            wlock_busy,
   output err_e            code
);
   logic is_acc, state_bad, timing_bad, mrd_bad, pre_bad;

   always_comb begin
      is_acc    = (cmd == CMD_RD) || (cmd == CMD_WR);
      pre_bad   = flag ? |(active & ras_busy) : (active[bank] && ras_busy[bank]);
      state_bad = (is_acc && !active[bank])
               || ((cmd == CMD_ACT) && active[bank])
               || (((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|active));
      timing_bad = (is_acc && (rcd_busy[bank] || wlock_busy))
                || ((cmd == CMD_ACT) && (rp_busy[bank] || rrd_busy))
                || ((cmd == CMD_PRE) && pre_bad);
      mrd_bad   = mrd_busy && (cmd != CMD_NOP) && (cmd != CMD_DESEL);
      if (mrd_bad)         code = ERR_MRD;
      else if (state_bad)  code = ERR_STATE;
      else if (timing_bad) code = ERR_TIMING;
      else                 code = ERR_NONE;
   end
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
   import ddr_mon_pkg::*;
#(
   parameter int TCK_NS    = 10,
   parameter int T_RCD_NS  = 20,
   parameter int T_RP_NS   = 20,
   parameter int T_RAS_NS  = 48,
   parameter int T_RRD_NS  = 15,
   parameter int MRD_CYC   = 2,
   parameter int BURST_LEN = 4,
   parameter int BA_W      = 2,
   parameter int ADDR_W    = 13,
   parameter int AP_BIT    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic [3:0]        cmd_o,
   output logic [BA_W-1:0]   bank_o,
   output logic              flag_o,
   output logic [ADDR_W-1:0] open_row_o,
   output logic [(1<<BA_W)-1:0] bank_active_o,
   output logic              viol_o,
   output logic [1:0]        err_code_o
);
   localparam int NB        = 1 << BA_W;
   localparam int RCD_CYC   = ns2cyc(T_RCD_NS, TCK_NS);
   localparam int RP_CYC    = ns2cyc(T_RP_NS, TCK_NS);
   localparam int RAS_CYC   = ns2cyc(T_RAS_NS, TCK_NS);
   localparam int RRD_CYC   = ns2cyc(T_RRD_NS, TCK_NS);
   localparam int BURST_CYC = BURST_LEN / 2;
   localparam int WLK_CYC   = BURST_CYC + 1;
   localparam int AP_CYC    = BURST_CYC + RP_CYC;
   localparam int MAXC      = imax(imax(imax(RCD_CYC, RAS_CYC), imax(RRD_CYC, MRD_CYC)),
                                   imax(AP_CYC, WLK_CYC));
   localparam int CW        = $clog2(MAXC + 1);

   if (TCK_NS < 1) begin : g_bad_tck
      $error("TCK_NS must be positive");
   end
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must lie inside the address bus");
   end
   if (BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
      $error("BURST_LEN must be 2, 4 or 8");
   end
   if (MRD_CYC < 1 || RCD_CYC < 1 || RP_CYC < 1 || RAS_CYC < 1 || RRD_CYC < 1) begin : g_bad_cyc
      $error("every spacing must be at least one clock");
   end

   cmd_e             cmd;
   err_e             code;
   logic             a10;
   logic [NB-1:0]    active, rcd_busy, rp_busy, ras_busy;
   logic [ADDR_W-1:0] row_arr [NB];
   logic [CW-1:0]    mrd_cnt, rrd_cnt, wlk_cnt;
   cmd_e             cmd_q;

   assign a10 = addr[AP_BIT];

   ddr_cmd_decode u_dec (
      .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic hit;
      assign hit = (ba == BA_W'(b));
      ddr_bank_timer #(
         .ROW_W(ADDR_W), .CW(CW),
         .RCD_LD(CW'(RCD_CYC - 1)), .RP_LD(CW'(RP_CYC - 1)),
         .RAS_LD(CW'(RAS_CYC - 1)), .AP_LD(CW'(AP_CYC - 1))
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .open_i((cmd == CMD_ACT) && hit),
         .close_i((cmd == CMD_PRE) && (a10 || hit)),
         .ap_close_i(((cmd == CMD_RD) || (cmd == CMD_WR)) && a10 && hit),
         .row_i(addr),
         .active_o(active[b]), .row_o(row_arr[b]),
         .rcd_busy_o(rcd_busy[b]), .rp_busy_o(rp_busy[b]), .ras_busy_o(ras_busy[b])
      );
   end

   ddr_rule_check #(.NB(NB), .BA_W(BA_W)) u_rules (
      .cmd(cmd), .bank(ba), .flag(a10), .active(active),
      .rcd_busy(rcd_busy), .rp_busy(rp_busy), .ras_busy(ras_busy),
      .mrd_busy(mrd_cnt != '0), .rrd_busy(rrd_cnt != '0), .wlock_busy(wlk_cnt != '0),
      .code(code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mrd_cnt <= '0;
         rrd_cnt <= '0;
         wlk_cnt <= '0;
      end else begin
         if (cmd == CMD_MRS)          mrd_cnt <= CW'(MRD_CYC - 1);
         else if (mrd_cnt != '0)      mrd_cnt <= mrd_cnt - 1'b1;
         if (cmd == CMD_ACT)          rrd_cnt <= CW'(RRD_CYC - 1);
         else if (rrd_cnt != '0)      rrd_cnt <= rrd_cnt - 1'b1;
         if (cmd == CMD_WR && a10)    wlk_cnt <= CW'(WLK_CYC - 1);
         else if (wlk_cnt != '0)      wlk_cnt <= wlk_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q      <= CMD_DESEL;
         bank_o     <= '0;
         flag_o     <= 1'b0;
         viol_o     <= 1'b0;
         err_code_o <= 2'd0;
      end else begin
         cmd_q  <= cmd;
         bank_o <= ba;
         flag_o <= a10 && ((cmd == CMD_RD) || (cmd == CMD_WR) || (cmd == CMD_PRE));
         if (!viol_o && (code != ERR_NONE)) begin
            viol_o     <= 1'b1;
            err_code_o <= code;
         end
      end
   end

   assign cmd_o         = cmd_q;
   assign bank_active_o = active;
   assign open_row_o    = row_arr[bank_o];
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk #(
   parameter int TCK_NS   = 10,
   parameter int T_RRD_NS = 15,
   parameter int MRD_CYC  = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic       cs_n,
   input logic [3:0] cmd_o,
   input logic       viol_o,
   input logic [1:0] err_code_o
);
   localparam int RRD_CYC = (T_RRD_NS + TCK_NS - 1) / TCK_NS;

   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |=> viol_o); // R11

   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |=> $stable(err_code_o)); // R11

   AST_CODE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> (err_code_o != 2'd0)); // R11

   AST_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke || cs_n) |=> (cmd_o == 4'd0)); // R3

   if (MRD_CYC > 1) begin : g_mrd
      AST_MRS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_o == 4'd2 && !viol_o) |=> (cmd_o == 4'd0 || cmd_o == 4'd1 || err_code_o == 2'd3)); // R8
   end

   if (RRD_CYC > 1) begin : g_rrd
      AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_o == 4'd4 && !viol_o) |=> (cmd_o != 4'd4 || viol_o)); // R7
   end
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(
   .TCK_NS(TCK_NS), .T_RRD_NS(T_RRD_NS), .MRD_CYC(MRD_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
   .cmd_o(cmd_o), .viol_o(viol_o), .err_code_o(err_code_o)
);

// File: tb/ddr_cmd_monitor_bench.sv
module ddr_cmd_monitor_bench;
   localparam logic [3:0] C_DES = 4'd0, C_NOP = 4'd1, C_MRS = 4'd2, C_REF = 4'd3,
                          C_ACT = 4'd4, C_RD  = 4'd5, C_WR  = 4'd6, C_BST = 4'd7,
                          C_PRE = 4'd8;
   // {cmd[3:0], bank[1:0], a10, expected bank_active[3:0]}
   localparam int NV = 25;
   localparam logic [10:0] VEC [NV] = '{
      {C_NOP,2'd0,1'b0,4'b0000}, {C_DES,2'd3,1'b0,4'b0000}, {C_MRS,2'd1,1'b0,4'b0000},
      {C_NOP,2'd0,1'b0,4'b0000}, {C_REF,2'd0,1'b0,4'b0000}, {C_ACT,2'd0,1'b0,4'b0001},
      {C_NOP,2'd0,1'b0,4'b0001}, {C_ACT,2'd1,1'b0,4'b0011}, {C_RD ,2'd0,1'b0,4'b0011},
      {C_WR ,2'd1,1'b0,4'b0011}, {C_BST,2'd0,1'b0,4'b0011}, {C_PRE,2'd0,1'b0,4'b0010},
      {C_DES,2'd1,1'b0,4'b0010}, {C_ACT,2'd0,1'b0,4'b0011}, {C_NOP,2'd0,1'b0,4'b0011},
      {C_NOP,2'd0,1'b0,4'b0011}, {C_NOP,2'd0,1'b0,4'b0011}, {C_ACT,2'd3,1'b0,4'b1011},
      {C_NOP,2'd0,1'b0,4'b1011}, {C_NOP,2'd0,1'b0,4'b1011}, {C_NOP,2'd0,1'b0,4'b1011},
      {C_NOP,2'd0,1'b0,4'b1011}, {C_PRE,2'd2,1'b1,4'b0000}, {C_NOP,2'd0,1'b0,4'b0000},
      {C_REF,2'd0,1'b0,4'b0000}
   };

   logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic [12:0] addr = '0;
   logic [3:0] cmd_o, bank_active_o;
   logic [1:0] bank_o, err_code_o;
   logic flag_o, viol_o;
   logic [12:0] open_row_o;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ddr_cmd_monitor u_ddr_cmd_monitor (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o), .flag_o(flag_o),
      .open_row_o(open_row_o), .bank_active_o(bank_active_o), .viol_o(viol_o),
      .err_code_o(err_code_o)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // called on a falling edge; returns on the next falling edge
   task automatic cyc(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a);
      cs_n = (c == C_DES);
      case (c)
         C_MRS:   {ras_n, cas_n, we_n} = 3'b000;
         C_REF:   {ras_n, cas_n, we_n} = 3'b001;
         C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
         C_RD:    {ras_n, cas_n, we_n} = 3'b101;
         C_WR:    {ras_n, cas_n, we_n} = 3'b100;
         C_BST:   {ras_n, cas_n, we_n} = 3'b110;
         C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
         C_DES:   {ras_n, cas_n, we_n} = 3'b000;
         default: {ras_n, cas_n, we_n} = 3'b111;
      endcase
      ba = b;
      addr = a;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic nops(input int n);
      for (int i = 0; i < n; i++) cyc(C_NOP, 2'd0, 13'd0);
   endtask

   task automatic reset_dut();
      @(negedge clk);
      rst_n = 1'b0;
      cke = 1'b1;
      cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   localparam logic [12:0] AP = 13'h0400;

   initial begin
      reset_dut();
      chk("R1 cmd", cmd_o, C_DES);
      chk("R1 viol", viol_o, 0);
      chk("R1 code", err_code_o, 0);
      chk("R1 banks", bank_active_o, 0);

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i][10:7], VEC[i][6:5], {2'b00, VEC[i][4], 10'(i)});
         chk("R2 decode", cmd_o, VEC[i][10:7]);
         chk("R5 bank state", bank_active_o, VEC[i][3:0]);
         chk("R7 legal run no violation", viol_o, 0);
         if (VEC[i][10:7] != C_DES) chk("R4 bank", bank_o, VEC[i][6:5]);
      end

      // R6 read of an idle bank
      reset_dut();
      cyc(C_RD, 2'd3, 13'd0);
      chk("R6 read idle viol", viol_o, 1);
      chk("R6 read idle code", err_code_o, 1);

      // R11 priority: activate of open bank the next clock is state, not timing
      reset_dut();
      chk("R1 cleared after reset", viol_o, 0);
      cyc(C_ACT, 2'd0, 13'd5);
      cyc(C_ACT, 2'd0, 13'd6);
      chk("R11 state beats timing", err_code_o, 1);

      // R7 activate-to-read spacing, then R11 sticky
      reset_dut();
      cyc(C_ACT, 2'd0, 13'd1);
      cyc(C_RD, 2'd0, 13'd0);
      chk("R7 act-to-read code", err_code_o, 2);
      cyc(C_RD, 2'd3, 13'd0);
      nops(3);
      chk("R11 sticky flag", viol_o, 1);
      chk("R11 sticky code", err_code_o, 2);

      // R7 activate-to-precharge
      reset_dut();
      cyc(C_ACT, 2'd0, 13'd1);
      nops(2);
      cyc(C_PRE, 2'd0, 13'd0);
      chk("R7 act-to-pre code", err_code_o, 2);

      // R7 precharge-to-activate
      reset_dut();
      cyc(C_ACT, 2'd0, 13'd1);
      nops(4);
      cyc(C_PRE, 2'd0, 13'd0);
      chk("R7 pre at 5 clocks legal", viol_o, 0);
      cyc(C_ACT, 2'd0, 13'd2);
      chk("R7 pre-to-act code", err_code_o, 2);

      // R7 activate-to-activate on different banks
      reset_dut();
      cyc(C_ACT, 2'd0, 13'd1);
      cyc(C_ACT, 2'd1, 13'd1);
      chk("R7 act-to-act code", err_code_o, 2);

      // R8 command inside mode-load quiet window
      reset_dut();
      cyc(C_MRS, 2'd0, 13'd0);
      cyc(C_ACT, 2'd0, 13'd0);
      chk("R8 quiet window code", err_code_o, 3);

      // R6 mode load with a bank open
      reset_dut();
      cyc(C_ACT, 2'd2, 13'd0);
      nops(1);
      cyc(C_MRS, 2'd0, 13'd0);
      chk("R6 mode load open bank code", err_code_o, 1);

      // R10 write auto-precharge lockout violated
      reset_dut();
      cyc(C_ACT, 2'd0, 13'd0);
      nops(1);
      cyc(C_ACT, 2'd1, 13'd0);
      nops(2);
      cyc(C_WR, 2'd0, AP);
      chk("R5 flag on auto-precharge", flag_o, 1);
      cyc(C_RD, 2'd1, 13'd0);
      chk("R10 lockout code", err_code_o, 2);

      // R10 legal after lockout, R9 bank closed by auto-precharge
      reset_dut();
      cyc(C_ACT, 2'd0, 13'd0);
      nops(1);
      cyc(C_ACT, 2'd1, 13'd0);
      nops(2);
      cyc(C_WR, 2'd0, AP);
      nops(2);
      cyc(C_RD, 2'd1, 13'd0);
      chk("R10 access after lockout legal", viol_o, 0);
      chk("R9 bank closed by auto-precharge", bank_active_o, 4'b0010);
      cyc(C_RD, 2'd0, 13'd0);
      chk("R9 read of auto-closed bank", err_code_o, 1);

      // R9 reopen after auto-precharge: legal at 4 clocks
      reset_dut();
      cyc(C_ACT, 2'd0, 13'd0);
      nops(1);
      cyc(C_RD, 2'd0, AP);
      nops(3);
      cyc(C_ACT, 2'd0, 13'd0);
      chk("R9 reopen at 4 clocks legal", viol_o, 0);

      // R9 reopen too soon
      reset_dut();
      cyc(C_ACT, 2'd0, 13'd0);
      nops(1);
      cyc(C_RD, 2'd0, AP);
      nops(2);
      cyc(C_ACT, 2'd0, 13'd0);
      chk("R9 reopen at 3 clocks code", err_code_o, 2);

      // R3 clock enable low hides a command
      reset_dut();
      cke = 1'b0;
      cyc(C_ACT, 2'd0, 13'd0);
      chk("R3 cke low cmd", cmd_o, C_DES);
      chk("R3 cke low banks", bank_active_o, 0);
      cke = 1'b1;
      cyc(C_RD, 2'd0, 13'd0);
      chk("R3 bank stayed idle", err_code_o, 1);

      // R4 stored rows
      reset_dut();
      cyc(C_ACT, 2'd2, 13'h1ABC);
      chk("R4 row after act", open_row_o, 13'h1ABC);
      chk("R4 bank after act", bank_o, 2);
      nops(1);
      cyc(C_ACT, 2'd1, 13'h0055);
      chk("R4 second row", open_row_o, 13'h0055);
      nops(1);
      cyc(C_RD, 2'd2, 13'h0003);
      chk("R4 row seen on read", open_row_o, 13'h1ABC);
      chk("R5 flag low on plain read", flag_o, 0);

      // R5 single and all-bank precharge
      reset_dut();
      cyc(C_ACT, 2'd0, 13'd0);
      nops(1);
      cyc(C_ACT, 2'd2, 13'd0);
      nops(4);
      cyc(C_PRE, 2'd1, 13'd0);
      chk("R5 single precharge other banks kept", bank_active_o, 4'b0101);
      cyc(C_PRE, 2'd1, AP);
      chk("R5 precharge all ignores bank", bank_active_o, 4'b0000);
      chk("R5 precharge all legal", viol_o, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule